// File: doc/BRIEF.md
# Shift and Boolean Functional Unit

This unit is one datapath element of a parallel processor. It holds two 16-bit operands in input registers, and each register loads only when its own enable bit is set. A control register holds an operating mode, a shift count and a Boolean function code. The control register keeps its value until the next control write. Because of this, a program sets the operation once and then streams data through at one result per clock by pulsing the operand enables.

The unit can do three things. It can shift operand A right logically, filling with zeros. It can rotate A right. It can apply any of the sixteen two-input bitwise functions to A and B. A fourth mode makes a 32-bit right shift across two units. The lower unit fills its vacated bits from the A operand of the upper unit, and that operand arrives through a link input fed by the upper unit's link output. Each result is registered. A flag that tells whether the result equals an auxiliary register is registered in the same edge, so the flag can be used for branch decisions.

Top module: `shbool_unit`

## Requirements
- R1: Each operand register loads its port value on a clock edge where its own enable (`a_ld`, `b_ld`) is 1 and holds otherwise. A value on an operand port with its enable at 0 leaves the result unchanged.
- R2: Mode, count and function are captured only on an edge with `ctl_wr` = 1. New control values presented without `ctl_wr` have no effect on later results.
- R3: The result register and the flag update on every clock edge from the operand, control and auxiliary register contents held just before that edge. A result therefore appears one edge after its operands and control are loaded.
- R4: Mode 2'b00 gives a logical right shift of A by the count (0 to 15), with zeros in the vacated high bits.
- R5: Mode 2'b01 gives a right rotate of A by the count, so bit i of the result is A[(i+count) mod 16].
- R6: Mode 2'b10 gives a bitwise Boolean function. Result bit i is bit {A[i],B[i]} of the 4-bit function code, with A as the high index bit. For example, code 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b1100 passes A and 4'b1010 passes B.
- R7: Mode 2'b11 gives the lower half of {link_in, A} shifted right by the count, so that the vacated high bits are filled with the low bits of `link_in`.
- R8: `link_out` always presents the contents of the A operand register.
- R9: `flag_out` is 1 exactly when the newly registered result equals the auxiliary register value in effect before that edge. The auxiliary register loads from `aux_in` when `aux_wr` = 1.
- R10: While reset is asserted, the result, flag, operands, auxiliary value and control fields are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 16 | Operand A data |
| a_ld | input | 1 | Load enable for operand A register |
| b_in | input | 16 | Operand B data |
| b_ld | input | 1 | Load enable for operand B register |
| ctl_wr | input | 1 | Control register write |
| ctl_mode | input | 2 | Mode: 00 shift, 01 rotate, 10 Boolean, 11 linked shift |
| ctl_cnt | input | 4 | Shift or rotate count |
| ctl_func | input | 4 | Boolean truth-table code |
| aux_in | input | 16 | Comparison value |
| aux_wr | input | 1 | Auxiliary register load enable |
| link_in | input | 16 | Fill bits from the upper unit for the linked shift |
| link_out | output | 16 | Current A operand for a lower unit |
| res_out | output | 16 | Registered result |
| flag_out | output | 1 | Registered equality of result and auxiliary value |

## Verification
Operands, control and the auxiliary value are presented together and captured on one edge. The result and flag are due on the next edge, so the bench samples them on the falling edge after that second edge. `link_out` is due one edge after an A load and is sampled on the falling edge that follows it. The hold checks work the same way: they change port values with the enables low, let two edges pass, and then confirm that the result still reflects the earlier contents.

// File: rtl/shbool_pkg.sv
package shbool_pkg;
  typedef enum logic [1:0] {
    SB_SHR  = 2'b00,
    SB_ROR  = 2'b01,
    SB_BOOL = 2'b10,
    SB_DSHR = 2'b11
  } sb_mode_e;

  typedef struct packed {
    sb_mode_e   mode;
    logic [3:0] func;
  } sb_op_t;
endpackage

// File: rtl/shbool_oreg.sv
module shbool_oreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/shbool_core.sv
module shbool_core
  import shbool_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  sb_op_t        op,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  link,
  output logic [W-1:0]  y
);
  // Right shift of v by n, vacated bits taken from fill (low bits first).
  function automatic logic [W-1:0] shift_fill(input logic [W-1:0] v,
                                              input logic [W-1:0] fill,
                                              input logic [CW-1:0] n);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      int s;
      s = i + int'(n);
      if (s < W) r[i] = v[s];
      else       r[i] = fill[s-W];
    end
    return r;
  endfunction

  // Per-bit truth table lookup, A is the high index bit.
  function automatic logic [W-1:0] bool_tt(input logic [W-1:0] x,
                                           input logic [W-1:0] z,
                                           input logic [3:0] tt);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = tt[{x[i], z[i]}];
    return r;
  endfunction

  logic [W-1:0] fill_sel;

  always_comb begin
    unique case (op.mode)
      SB_ROR:  fill_sel = a;
      SB_DSHR: fill_sel = link;
      default: fill_sel = '0;
    endcase
  end

  always_comb begin
    if (op.mode == SB_BOOL) y = bool_tt(a, b, op.func);
    else                    y = shift_fill(a, fill_sel, cnt);
  end
endmodule

// File: rtl/shbool_unit.sv
module shbool_unit
  import shbool_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic          a_ld,
  input  logic [W-1:0]  b_in,
  input  logic          b_ld,
  input  logic          ctl_wr,
  input  logic [1:0]    ctl_mode,
  input  logic [CW-1:0] ctl_cnt,
  input  logic [3:0]    ctl_func,
  input  logic [W-1:0]  aux_in,
  input  logic          aux_wr,
  input  logic [W-1:0]  link_in,
  output logic [W-1:0]  link_out,
  output logic [W-1:0]  res_out,
  output logic          flag_out
);
  logic [W-1:0]  a_q, b_q, aux_q;
  sb_op_t        op_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  res_d;
  logic          match_d;

  shbool_oreg #(.W(W)) u_areg   (.clk(clk), .rst_n(rst_n), .ld(a_ld),   .d(a_in),   .q(a_q));
  shbool_oreg #(.W(W)) u_breg   (.clk(clk), .rst_n(rst_n), .ld(b_ld),   .d(b_in),   .q(b_q));
  shbool_oreg #(.W(W)) u_auxreg (.clk(clk), .rst_n(rst_n), .ld(aux_wr), .d(aux_in), .q(aux_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '{mode: SB_SHR, func: 4'h0};
      cnt_q <= '0;
    end else if (ctl_wr) begin
      op_q  <= '{mode: sb_mode_e'(ctl_mode), func: ctl_func};
      cnt_q <= ctl_cnt;
    end
  end

  shbool_core #(.W(W), .CW(CW)) u_core (
    .op(op_q), .cnt(cnt_q), .a(a_q), .b(b_q), .link(link_in), .y(res_d)
  );

  assign match_d = (res_d == aux_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out  <= '0;
      flag_out <= 1'b0;
    end else begin
      res_out  <= res_d;
      flag_out <= match_d;
    end
  end

  assign link_out = a_q;
endmodule

// File: rtl/shbool_chk.sv
module shbool_chk
  import shbool_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_ld,
  input logic          ctl_wr,
  input logic [W-1:0]  a_q,
  input logic [W-1:0]  aux_q,
  input sb_op_t        op_q,
  input logic [CW-1:0] cnt_q,
  input logic [W-1:0]  res_out,
  input logic          flag_out
);
  a_r1_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ld |=> $stable(a_q));

  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ($stable(op_q) && $stable(cnt_q)));

  a_r4_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q.mode == SB_SHR && cnt_q != '0) |=> !res_out[W-1]);

  a_r5_rot_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q.mode == SB_ROR) |=> ($countones(res_out) == $countones($past(a_q))));

  a_r9_flag_eq: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_out == (res_out == $past(aux_q))));
endmodule

bind shbool_unit shbool_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_ld(a_ld), .ctl_wr(ctl_wr), .a_q(a_q),
  .aux_q(aux_q), .op_q(op_q), .cnt_q(cnt_q), .res_out(res_out), .flag_out(flag_out)
);

// File: tb/shbool_unit_tb_top.sv
module shbool_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0, aux_in = '0, link_in = '0;
  logic a_ld = 1'b0, b_ld = 1'b0, ctl_wr = 1'b0, aux_wr = 1'b0;
  logic [1:0] ctl_mode = '0;
  logic [3:0] ctl_cnt = '0, ctl_func = '0;
  logic [15:0] link_out, res_out;
  logic flag_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shbool_unit dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ld(a_ld), .b_in(b_in), .b_ld(b_ld),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_cnt(ctl_cnt), .ctl_func(ctl_func),
    .aux_in(aux_in), .aux_wr(aux_wr), .link_in(link_in), .link_out(link_out),
    .res_out(res_out), .flag_out(flag_out)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [1:0] m, logic [3:0] n, logic [3:0] f,
                                        logic [15:0] a, logic [15:0] b, logic [15:0] l);
    logic [31:0] t;
    logic [15:0] r;
    case (m)
      2'b00: t = {16'h0, a} >> n;
      2'b01: t = {a, a} >> n;
      2'b11: t = {l, a} >> n;
      default: begin
        for (int i = 0; i < 16; i++)
          r[i] = (a[i] & b[i] & f[3]) | (a[i] & ~b[i] & f[2]) |
                 (~a[i] & b[i] & f[1]) | (~a[i] & ~b[i] & f[0]);
        t = {16'h0, r};
      end
    endcase
    return t[15:0];
  endfunction

  // Loads operands, control and aux in one edge; result due on the next.
  task automatic run(string req, logic [1:0] m, logic [3:0] n, logic [3:0] f,
                     logic [15:0] a, logic [15:0] b, logic [15:0] l, bit want_eq);
    logic [15:0] e;
    e = model(m, n, f, a, b, l);
    @(negedge clk);
    a_in = a; b_in = b; link_in = l; a_ld = 1; b_ld = 1;
    ctl_wr = 1; ctl_mode = m; ctl_cnt = n; ctl_func = f;
    aux_wr = 1; aux_in = want_eq ? e : ~e;
    @(negedge clk);
    a_ld = 0; b_ld = 0; ctl_wr = 0; aux_wr = 0;
    check({req, " link_out"}, link_out, a);
    @(negedge clk);
    check(req, res_out, e);
    check({"R9 flag ", req}, {15'h0, flag_out}, {15'h0, want_eq});
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hB38D; pats[1] = 16'h8001; pats[2] = 16'hFFFF; pats[3] = 16'h1234;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 res", res_out, 16'h0);
    check("R10 flag", {15'h0, flag_out}, 16'h0);
    check("R10 link", link_out, 16'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 16; n++) begin
        run("R4 shr", 2'b00, 4'(n), 4'h0, pats[p], 16'h5555, 16'h0, (n % 3) == 0);
        run("R5 ror", 2'b01, 4'(n), 4'h0, pats[p], 16'hAAAA, 16'h0, (n % 2) == 0);
      end
    for (int n = 0; n < 16; n++) begin
      run("R7 dshr", 2'b11, 4'(n), 4'h0, 16'h8421, 16'h0, 16'hC3A5, n != 5);
      run("R7 dshr", 2'b11, 4'(n), 4'h0, 16'hFFFF, 16'h0, 16'h0001, 1'b1);
    end
    for (int f = 0; f < 16; f++) begin
      run("R6 bool", 2'b10, 4'(f), 4'(f), 16'hF0F0, 16'hCCCC, 16'h0, 1'b1);
      run("R6 bool", 2'b10, 4'hF - 4'(f), 4'(f), 16'h1E87, 16'h6B39, 16'h0, f != 7);
    end
    // R1: operand registers ignore port data while enables are low
    run("R1 setup", 2'b10, 4'h0, 4'b1100, 16'h3C5A, 16'h0, 16'h0, 1'b1);
    @(negedge clk); a_in = 16'hFFFF; b_in = 16'h9999;
    @(negedge clk); @(negedge clk);
    check("R1 a hold", res_out, 16'h3C5A);
    check("R8 link hold", link_out, 16'h3C5A);
    // R2: control fields without ctl_wr have no effect
    ctl_mode = 2'b01; ctl_func = 4'b1010; ctl_cnt = 4'h4;
    @(negedge clk); @(negedge clk);
    check("R2 ctl hold", res_out, 16'h3C5A);
    // R1/R3: B loads alone, then pass-B function reveals it one edge later
    ctl_wr = 1; ctl_mode = 2'b10; ctl_func = 4'b1010; b_ld = 1; b_in = 16'h0F1E;
    @(negedge clk);
    ctl_wr = 0; b_ld = 0; b_in = 16'h7777;
    check("R3 before edge", res_out, 16'h3C5A);
    @(negedge clk);
    check("R1 b load", res_out, 16'h0F1E);
    @(negedge clk);
    check("R1 b hold", res_out, 16'h0F1E);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule